// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block adds up the values of coins as they arrive and raises a dispense pulse once the sum reaches a price. A one-bit strobe flags that a coin has been seen. A parallel value bus carries the coin's worth. A price input sets the threshold. A small four-state controller (clear, idle, accumulate, release) sequences an adder-fed total register, and a magnitude comparator sets the threshold test.

Every register updates only on the clock edge that leaves the state that assigned it. Two things follow. The threshold test always sees the sum already built, never the coin being added. The release pulse appears in the cycle after the release state, and the sum is cleared by the clear state that follows it. The price is read combinationally whenever the controller is idle, so it may change between purchases.

Top module: `vend_top`

## Requirements
- R1: A synchronous active-high reset puts the controller in the clear state, zeroes the total and holds the dispense output at 0. Dispense is 0 in the first cycle after reset is released.
- R2: The clear state zeroes the total and drives dispense to 0 on its exit edge. It always moves to the idle state after one cycle.
- R3: In the idle state, an asserted coin strobe moves the controller to the accumulate state. The coin value is sampled in the accumulate cycle, which is the cycle after the strobe, and is added to the total. The controller then returns to idle.
- R4: In the idle state with no strobe, the controller stays idle and the total is unchanged while the total is below the price. It moves to the release state once the total is greater than or equal to the price, compared as unsigned numbers.
- R5: Dispense is 1 for exactly one cycle. That cycle is the one right after the release state, during which the controller is in the clear state.
- R6: The total is DATA_W bits wide and wraps modulo 2^DATA_W, with no saturation.
- R7: A strobe held high adds the coin value once for each idle/accumulate round trip, so four cycles of strobe add the value twice.
- R8: With a price of 0, the controller cycles clear, idle, release without a coin and raises dispense once every three cycles.
- R9: A strobe in the idle state takes priority over the threshold test. A coin arriving in the cycle the total first meets the price is added before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_i | input | 1 | Coin-detect strobe, one cycle per coin |
| coin_val_i | input | DATA_W | Coin value, sampled in the accumulate cycle |
| price_i | input | DATA_W | Item price threshold |
| dispense_o | output | 1 | Registered release pulse, 1 means dispense |

## Verification
The bench builds the block with the default DATA_W of 8. At that width, two 150-unit coins overflow the sum to 44 in a handful of cycles, so the wrap of R6 is checked exactly against a price of 200. The narrow width also keeps every threshold, including a zero price and a total that matches the price exactly, within short directed sequences. The total is inferred at the ports by moving the price one unit either side of the expected sum and watching whether dispense follows.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_WAIT = 2'd1,
    ST_ADD  = 2'd2,
    ST_DISP = 2'd3
  } vend_state_e;

endpackage

// File: rtl/vend_cmp.sv
module vend_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] total_i,
  input  logic [DATA_W-1:0] price_i,
  output logic              reached_o
);

  // unsigned magnitude compare: total has met or passed the price
  always_comb begin
    reached_o = (total_i >= price_i);
  end

endmodule

// File: rtl/vend_accum.sv
module vend_accum #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] coin_val_i,
  output logic [DATA_W-1:0] total_o
);

  logic [DATA_W-1:0] total_q;
  logic [DATA_W-1:0] sum;

  // modulo-2^DATA_W adder, carry out dropped
  always_comb begin
    sum = total_q + coin_val_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      total_q <= '0;
    end else if (ld_i) begin
      total_q <= sum;
    end
  end

  assign total_o = total_q;

endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
  import vend_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        coin_i,
  input  logic        reached_i,
  output vend_state_e state_o,
  output logic        clr_o,
  output logic        ld_o,
  output logic        disp_set_o,
  output logic        disp_clr_o
);

  vend_state_e state_q;
  vend_state_e state_d;

  always_comb begin
    state_d    = state_q;
    clr_o      = 1'b0;
    ld_o       = 1'b0;
    disp_set_o = 1'b0;
    disp_clr_o = 1'b0;
    unique case (state_q)
      ST_INIT: begin
        clr_o      = 1'b1;
        disp_clr_o = 1'b1;
        state_d    = ST_WAIT;
      end
      ST_WAIT: begin
        if (coin_i) begin
          state_d = ST_ADD;
        end else if (reached_i) begin
          state_d = ST_DISP;
        end
      end
      ST_ADD: begin
        ld_o    = 1'b1;
        state_d = ST_WAIT;
      end
      ST_DISP: begin
        disp_set_o = 1'b1;
        state_d    = ST_INIT;
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/vend_top.sv
module vend_top
  import vend_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coin_i,
  input  logic [DATA_W-1:0] coin_val_i,
  input  logic [DATA_W-1:0] price_i,
  output logic              dispense_o
);

  vend_state_e       state_q;
  logic [DATA_W-1:0] total_q;
  logic              reached;
  logic              clr;
  logic              ld;
  logic              disp_set;
  logic              disp_clr;
  logic              disp_q;

  vend_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .coin_i     (coin_i),
    .reached_i  (reached),
    .state_o    (state_q),
    .clr_o      (clr),
    .ld_o       (ld),
    .disp_set_o (disp_set),
    .disp_clr_o (disp_clr)
  );

  vend_accum #(.DATA_W(DATA_W)) u_accum (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .ld_i       (ld),
    .coin_val_i (coin_val_i),
    .total_o    (total_q)
  );

  vend_cmp #(.DATA_W(DATA_W)) u_cmp (
    .total_i   (total_q),
    .price_i   (price_i),
    .reached_o (reached)
  );

  // registered dispense: set when leaving release, cleared when leaving clear
  always_ff @(posedge clk) begin
    if (rst || disp_clr) begin
      disp_q <= 1'b0;
    end else if (disp_set) begin
      disp_q <= 1'b1;
    end
  end

  assign dispense_o = disp_q;

endmodule

// File: rtl/vend_chk.sv
module vend_chk
  import vend_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              coin_i,
  input logic [DATA_W-1:0] coin_val_i,
  input logic [DATA_W-1:0] price_i,
  input logic              dispense_o,
  input vend_state_e       state_q,
  input logic [DATA_W-1:0] total_q
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state_q == ST_INIT) && (total_q == '0) && !dispense_o);

  // R2
  init_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_INIT) |=> (state_q == ST_WAIT) && (total_q == '0));

  // R3
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADD) |=> (state_q == ST_WAIT) &&
      (total_q == DATA_W'($past(total_q) + $past(coin_val_i))));

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !coin_i && total_q < price_i) |=>
      (state_q == ST_WAIT) && $stable(total_q));

  // R4
  wait_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !coin_i && total_q >= price_i) |=> (state_q == ST_DISP));

  // R5
  disp_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DISP) |=> dispense_o);

  // R5
  disp_single_chk: assert property (@(posedge clk) disable iff (rst)
    dispense_o |=> !dispense_o);

  // R5
  disp_in_init_chk: assert property (@(posedge clk) disable iff (rst)
    dispense_o |-> (state_q == ST_INIT));

  // R9
  coin_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && coin_i) |=> (state_q == ST_ADD));

endmodule

bind vend_top vend_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .coin_i     (coin_i),
  .coin_val_i (coin_val_i),
  .price_i    (price_i),
  .dispense_o (dispense_o),
  .state_q    (state_q),
  .total_q    (total_q)
);

// File: tb/tb_vend_top.sv
`timescale 1ns/1ps
module tb_vend_top;

  localparam int DATA_W = 8;
  localparam int TIMEOUT_CYC = 200000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              coin_i = 1'b0;
  logic [DATA_W-1:0] coin_val_i = '0;
  logic [DATA_W-1:0] price_i = '0;
  logic              dispense_o;

  int total_chk = 0;
  int bad_chk = 0;

  always #2 clk = ~clk;

  vend_top #(.DATA_W(DATA_W)) dut (
    .clk        (clk),
    .rst        (rst),
    .coin_i     (coin_i),
    .coin_val_i (coin_val_i),
    .price_i    (price_i),
    .dispense_o (dispense_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_disp(input logic exp, input string tag);
    total_chk++;
    if (dispense_o !== exp) begin
      bad_chk++;
      $display("FAIL %s: dispense actual=%b expected=%b", tag, dispense_o, exp);
    end
  endtask

  task automatic step(input logic exp, input string tag);
    tick();
    chk_disp(exp, tag);
  endtask

  // reset, leaves the controller in the clear state
  task automatic do_reset();
    rst = 1'b1;
    coin_i = 1'b0;
    coin_val_i = '0;
    tick();
    tick();
    rst = 1'b0;
  endtask

  // one coin from idle; returns in idle after the add
  task automatic ins(input logic [DATA_W-1:0] v);
    coin_i = 1'b1;
    coin_val_i = v;
    tick();
    coin_i = 1'b0;
    tick();
    coin_val_i = '0;
  endtask

  task automatic t_basic();
    price_i = 8'd30;
    do_reset();
    chk_disp(1'b0, "R1 after reset");
    step(1'b0, "R2 init to wait");
    ins(8'd10);
    chk_disp(1'b0, "R4 below price");
    ins(8'd10);
    ins(8'd10);
    chk_disp(1'b0, "R4 just reached");
    step(1'b0, "R4 release state");
    step(1'b1, "R5 dispense pulse");
    step(1'b0, "R5 single pulse");
    for (int i = 0; i < 4; i++) step(1'b0, "R2 total cleared");
  endtask

  task automatic t_wrap();
    price_i = 8'd200;
    do_reset();
    tick();
    ins(8'd150);
    ins(8'd150);
    for (int i = 0; i < 4; i++) step(1'b0, "R6 wrapped to 44");
    ins(8'd156);
    step(1'b0, "R6 release state");
    step(1'b1, "R6 exact 200 dispense");
    step(1'b0, "R5 pulse width");
  endtask

  task automatic t_zero_price();
    price_i = 8'd0;
    do_reset();
    for (int r = 0; r < 3; r++) begin
      step(1'b0, "R8 wait");
      step(1'b0, "R8 release");
      step(1'b1, "R8 dispense");
    end
  endtask

  task automatic t_held();
    price_i = 8'd100;
    do_reset();
    tick();
    coin_i = 1'b1;
    coin_val_i = 8'd10;
    for (int i = 0; i < 4; i++) tick();
    coin_i = 1'b0;
    coin_val_i = '0;
    price_i = 8'd21;
    step(1'b0, "R7 total below 21");
    step(1'b0, "R7 total below 21");
    price_i = 8'd20;
    step(1'b0, "R7 release state");
    step(1'b1, "R7 total equals 20");
  endtask

  task automatic t_sample();
    price_i = 8'd100;
    do_reset();
    tick();
    coin_i = 1'b1;
    coin_val_i = 8'd99;
    tick();
    coin_i = 1'b0;
    coin_val_i = 8'd7;
    tick();
    coin_val_i = '0;
    price_i = 8'd8;
    step(1'b0, "R3 value from add cycle");
    step(1'b0, "R3 value from add cycle");
    price_i = 8'd7;
    step(1'b0, "R3 release state");
    step(1'b1, "R3 total equals 7");
  endtask

  task automatic t_priority();
    price_i = 8'd30;
    do_reset();
    tick();
    ins(8'd20);
    coin_i = 1'b1;
    coin_val_i = 8'd20;
    tick();
    coin_i = 1'b0;
    tick();
    coin_i = 1'b1;
    coin_val_i = 8'd5;
    step(1'b0, "R9 coin taken first");
    coin_i = 1'b0;
    step(1'b0, "R9 no early dispense");
    coin_val_i = '0;
    step(1'b0, "R9 release state");
    step(1'b1, "R9 dispense after coin");
  endtask

  task automatic t_mid_reset();
    price_i = 8'd30;
    do_reset();
    tick();
    ins(8'd20);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk_disp(1'b0, "R1 mid reset");
    price_i = 8'd15;
    step(1'b0, "R1 total zeroed");
    step(1'b0, "R1 total zeroed");
    step(1'b0, "R1 total zeroed");
    ins(8'd15);
    step(1'b0, "R4 release state");
    step(1'b1, "R4 dispense at 15");
  endtask

  initial begin
    t_basic();
    t_wrap();
    t_zero_price();
    t_held();
    t_sample();
    t_priority();
    t_mid_reset();
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    #(TIMEOUT_CYC * 4);
    total_chk++;
    bad_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule